// File: doc/BRIEF.md
# I2C Slave Register Control Port

This block is a slave on a two-wire serial bus that gives a master access to a bank of eight-bit control registers. It answers to one seven-bit bus address. The upper five bits of that address are fixed at `10011`. The lower two bits come from a pair of select pins, so up to four identical devices can share one bus. The bus lines are oversampled by a fast system clock. They pass through a synchronizer and an edge detector, and the block drives the data line only through an open-drain pull-down enable.

In a write transfer, the first data byte after the address sets an internal register pointer. Each later byte is written to the register at the pointer, and the pointer then advances. In a read transfer, the block returns the register at the pointer one byte at a time, most significant bit first, and advances the pointer for every byte it sends. The burst continues until the master refuses a byte. A repeated start takes the block straight back to address reception. The pointer keeps its value from one transaction to the next.

Top module: `i2c_ctl_slave`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal {1,0,0,1,1,sel_i[1],sel_i[0]}, MSB first. It does this by asserting sda_oe_o (SDA pulled low) through the ninth SCL clock. The eighth bit of the byte selects the direction: 1 is a read, 0 is a write.
- R2: On an address mismatch, sda_oe_o stays low on the ninth clock. The block then ignores the bus, issuing no write strobe and no acknowledge, until the next start condition.
- R3: In a write transfer, the block acknowledges the first data byte and loads that byte into the register pointer. It does not pulse the write strobe for this byte.
- R4: Every later data byte is acknowledged and produces a one-cycle reg_we_o pulse, with reg_addr_o equal to the pointer and reg_wdata_o equal to the byte. The pointer then advances by one and wraps from 0xFF to 0x00.
- R5: In a read transfer, each byte is taken from reg_rdata_i at reg_addr_o and sent MSB first. The pointer advances by one for each byte that is loaded for sending.
- R6: If the master acknowledges a read byte (SDA low on the ninth clock), the next byte follows. If it does not (SDA high), the block releases SDA and drives nothing more until a new start condition.
- R7: A start condition that arrives without a preceding stop (a repeated start) restarts address reception and releases SDA.
- R8: A stop condition (SDA rising while SCL is high), or a stop in the middle of a byte, releases SDA and leaves the block idle. The next transfer works normally.
- R9: sda_oe_o changes only while the synchronized SCL is low.
- R10: After reset, sda_oe_o and reg_we_o are low and the register pointer is 0x00.
- R11: The pointer keeps its value across transactions, so a new read continues from where the previous transfer left off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that oversamples SCL and SDA |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line, sensed |
| sel_i | input | 2 | Low two bits of the bus address |
| sda_oe_o | output | 1 | Open-drain pull-down enable for SDA |
| reg_addr_o | output | ADDR_W | Register pointer presented to the register bank |
| reg_wdata_o | output | 8 | Write data to the register bank |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_rdata_i | input | 8 | Read data from the register at reg_addr_o |

## Verification
A table of single-register write-then-readback transfers tries the main function with several addresses. Matching addresses show that the pointer load and the strobed write reach the intended register. Addresses that differ only in one select bit, or only in the fixed prefix, show that every address bit is compared. Directed bursts separate the pointer-loading byte from the data bytes. They also show pointer wrap at 0xFF, continuation after an acknowledged read byte versus silence after a refused one, and a pointer that carries across transactions. Changing the select pins, and breaking a byte off with a stop, show that the address follows the pins and that the block recovers to the idle state.

// File: rtl/i2c_ctl_pkg.sv
package i2c_ctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } state_e;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/i2c_ctl_sync.sv
module i2c_ctl_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int unsigned NLINES = 2;

  logic [NLINES-1:0] raw_v, sync_v, prev_v;

  assign raw_v = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [STAGES-1:0] ff_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= '1;
      else         ff_q <= {ff_q[STAGES-2:0], raw_v[g]};
    end
    assign sync_v[g] = ff_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_v <= '1;
    else         prev_v <= sync_v;
  end

  assign scl_s_o    = sync_v[1];
  assign sda_s_o    = sync_v[0];
  assign scl_rise_o = sync_v[1] & ~prev_v[1];
  assign scl_fall_o = ~sync_v[1] & prev_v[1];
  // SCL held high across the sample, SDA moved
  assign start_o    = sync_v[1] & prev_v[1] & prev_v[0] & ~sync_v[0];
  assign stop_o     = sync_v[1] & prev_v[1] & ~prev_v[0] & sync_v[0];
endmodule

// File: rtl/i2c_ctl_fsm.sv
module i2c_ctl_fsm
  import i2c_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [4:0]  PREFIX = 5'b10011
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [1:0]        sel_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic              sda_oe_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic              we_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

  state_e             state_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [BYTE_W-1:0]  rx_q, tx_q, wdata_q;
  logic [ADDR_W-1:0]  ptr_q;
  logic               oe_q, rd_q, ptr_set_q, we_q;
  logic [BYTE_W-1:0]  rx_next;

  assign rx_next = {rx_q[BYTE_W-2:0], sda_s_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      wdata_q   <= '0;
      ptr_q     <= '0;
      oe_q      <= 1'b0;
      rd_q      <= 1'b0;
      ptr_set_q <= 1'b0;
      we_q      <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (we_q) ptr_q <= ptr_q + 1'b1;
      if (start_i) begin
        state_q   <= ST_ADDR;
        cnt_q     <= '0;
        oe_q      <= 1'b0;
        ptr_set_q <= 1'b0;
      end else if (stop_i) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR: begin
            if (scl_rise_i) begin
              rx_q  <= rx_next;
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == LAST) begin
              if (rx_q[7:1] == {PREFIX, sel_i}) begin
                state_q <= ST_ADDR_ACK;
                oe_q    <= 1'b1;
                rd_q    <= rx_q[0];
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: if (scl_fall_i) begin
            cnt_q <= '0;
            if (rd_q) begin
              state_q <= ST_RD;
              tx_q    <= rdata_i;
              oe_q    <= ~rdata_i[BYTE_W-1];
              ptr_q   <= ptr_q + 1'b1;
            end else begin
              state_q <= ST_WR;
              oe_q    <= 1'b0;
            end
          end
          ST_WR: begin
            if (scl_rise_i) begin
              rx_q  <= rx_next;
              cnt_q <= cnt_q + 1'b1;
              if (cnt_q == LAST - 1'b1) begin
                if (!ptr_set_q) begin
                  ptr_q     <= rx_next[ADDR_W-1:0];
                  ptr_set_q <= 1'b1;
                end else begin
                  we_q    <= 1'b1;
                  wdata_q <= rx_next;
                end
              end
            end else if (scl_fall_i && cnt_q == LAST) begin
              state_q <= ST_WR_ACK;
              oe_q    <= 1'b1;
            end
          end
          ST_WR_ACK: if (scl_fall_i) begin
            state_q <= ST_WR;
            oe_q    <= 1'b0;
            cnt_q   <= '0;
          end
          ST_RD: begin
            if (scl_rise_i) begin
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i) begin
              if (cnt_q == LAST) begin
                state_q <= ST_RD_ACK;
                oe_q    <= 1'b0;
              end else begin
                tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
                oe_q <= ~tx_q[BYTE_W-2];
              end
            end
          end
          ST_RD_ACK: begin
            // master NACK ends the burst; ACK loads the next byte
            if (scl_rise_i && sda_s_i) begin
              state_q <= ST_IDLE;
            end else if (scl_fall_i) begin
              state_q <= ST_RD;
              cnt_q   <= '0;
              tx_q    <= rdata_i;
              oe_q    <= ~rdata_i[BYTE_W-1];
              ptr_q   <= ptr_q + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o = oe_q;
  assign ptr_o    = ptr_q;
  assign wdata_o  = wdata_q;
  assign we_o     = we_q;
endmodule

// File: rtl/i2c_ctl_slave.sv
module i2c_ctl_slave #(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [4:0]  PREFIX      = 5'b10011
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [1:0]        sel_i,
  output logic              sda_oe_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [7:0]        reg_wdata_o,
  output logic              reg_we_o,
  input  logic [7:0]        reg_rdata_i
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;

  i2c_ctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_s_o    (scl_s),
    .sda_s_o    (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_evt),
    .stop_o     (stop_evt)
  );

  i2c_ctl_fsm #(.ADDR_W(ADDR_W), .PREFIX(PREFIX)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_s_i    (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_evt),
    .stop_i     (stop_evt),
    .sel_i      (sel_i),
    .rdata_i    (reg_rdata_i),
    .sda_oe_o   (sda_oe_o),
    .ptr_o      (reg_addr_o),
    .wdata_o    (reg_wdata_o),
    .we_o       (reg_we_o)
  );
endmodule

// File: rtl/i2c_ctl_slave_chk.sv
module i2c_ctl_slave_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_s,
  input logic scl_rise,
  input logic start_evt,
  input logic stop_evt,
  input logic sda_oe_o,
  input logic reg_we_o
);
  // R9
  oe_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !$past(scl_s));

  // R4
  we_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  // R4
  we_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> $past(scl_rise));

  // R8
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_evt |=> !sda_oe_o);

  // R7
  start_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_evt |=> !sda_oe_o);
endmodule

bind i2c_ctl_slave i2c_ctl_slave_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_s     (scl_s),
  .scl_rise  (scl_rise),
  .start_evt (start_evt),
  .stop_evt  (stop_evt),
  .sda_oe_o  (sda_oe_o),
  .reg_we_o  (reg_we_o)
);

// File: tb/i2c_ctl_slave_bench.sv
module i2c_ctl_slave_bench;
  localparam int Q = 10;
  localparam int NVEC = 6;
  // {bus address, pointer, data, ack expected}
  localparam logic [23:0] VEC [NVEC] = '{
    {7'h4E, 8'h10, 8'hA5, 1'b1},
    {7'h4E, 8'hFE, 8'h3C, 1'b1},
    {7'h4F, 8'h11, 8'h77, 1'b0},
    {7'h4C, 8'h12, 8'h66, 1'b0},
    {7'h0E, 8'h13, 8'h55, 1'b0},
    {7'h4E, 8'h00, 8'hC3, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [1:0] sel = 2'b10;
  logic sda_oe, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic sda_bus;
  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  int we_cnt = 0;
  logic [7:0] last_addr, last_data;
  int n_chk = 0, n_fail = 0, scl_hi_changes = 0;
  logic oe_seen = 1'b0, prev_oe = 1'b0;

  always #2 clk = ~clk;
  assign sda_bus   = m_sda & ~sda_oe;
  assign reg_rdata = mem[reg_addr];

  i2c_ctl_slave u_i2c_ctl_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sel_i(sel),
    .sda_oe_o(sda_oe), .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata),
    .reg_we_o(reg_we), .reg_rdata_i(reg_rdata)
  );

  always @(posedge clk) begin
    if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
      we_cnt    <= we_cnt + 1;
      last_addr <= reg_addr;
      last_data <= reg_wdata;
    end
    if (sda_oe != prev_oe && m_scl) scl_hi_changes <= scl_hi_changes + 1;
    if (sda_oe) oe_seen <= 1'b1;
    prev_oe <= sda_oe;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b1; tick(Q);
  endtask

  task automatic put_bit(input logic b);
    m_sda = b; tick(Q); m_scl = 1'b1; tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
    ack = ~sda_bus;
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic get_byte(input logic ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); m_scl = 1'b1; tick(Q);
      b[i] = sda_bus;
      m_scl = 1'b0;
    end
    m_sda = ~ack; tick(Q); m_scl = 1'b1; tick(Q); m_scl = 1'b0; tick(Q);
    m_sda = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] b;
    int we0;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i) ^ 8'h5A;
      exp_mem[i] = 8'(i) ^ 8'h5A;
    end
    tick(5);
    check(sda_oe == 1'b0, "R10 oe in reset", 32'(sda_oe), 0);
    rst_n = 1'b1; tick(5);
    check(sda_oe == 1'b0 && reg_we == 1'b0, "R10 idle after reset", {sda_oe, reg_we}, 0);
    check(reg_addr == 8'h00, "R10 pointer reset", 32'(reg_addr), 0);

    // R10/R5: read with untouched pointer returns register 0
    bus_start(); send_byte({7'h4E, 1'b1}, ack);
    check(ack, "R1 read address ack", 32'(ack), 1);
    get_byte(1'b0, b); bus_stop();
    check(b == exp_mem[0], "R5 read at reset pointer", 32'(b), 32'(exp_mem[0]));

    // table: write one register, read it back through a repeated start
    for (int v = 0; v < NVEC; v++) begin
      logic [6:0] a; logic [7:0] p, d; logic e;
      {a, p, d, e} = VEC[v];
      we0 = we_cnt;
      bus_start(); send_byte({a, 1'b0}, ack);
      check(ack == e, "R1/R2 address compare", 32'(ack), 32'(e));
      send_byte(p, ack);
      check(ack == e, "R3 pointer byte ack", 32'(ack), 32'(e));
      send_byte(d, ack);
      check(ack == e, "R4 data byte ack", 32'(ack), 32'(e));
      bus_stop();
      if (e) begin
        exp_mem[p] = d;
        check(we_cnt == we0 + 1, "R3 single strobe", 32'(we_cnt - we0), 1);
        check(last_addr == p && last_data == d, "R4 strobe addr/data", {last_addr, last_data}, {p, d});
        bus_start(); send_byte({a, 1'b0}, ack); send_byte(p, ack);
        bus_start(); send_byte({a, 1'b1}, ack);   // R7 repeated start
        check(ack, "R7 ack after repeated start", 32'(ack), 1);
        get_byte(1'b0, b); bus_stop();
        check(b == exp_mem[p], "R5 readback", 32'(b), 32'(exp_mem[p]));
      end else begin
        check(we_cnt == we0, "R2 no strobe on mismatch", 32'(we_cnt - we0), 0);
      end
    end

    // burst write then burst read
    we0 = we_cnt;
    bus_start(); send_byte({7'h4E, 1'b0}, ack); send_byte(8'h20, ack);
    send_byte(8'h11, ack); send_byte(8'h22, ack); send_byte(8'h33, ack);
    bus_stop();
    exp_mem[8'h20] = 8'h11; exp_mem[8'h21] = 8'h22; exp_mem[8'h22] = 8'h33;
    check(we_cnt == we0 + 3, "R4 burst strobes", 32'(we_cnt - we0), 3);
    check(mem[8'h22] == 8'h33, "R4 incremented address", 32'(mem[8'h22]), 32'h33);
    bus_start(); send_byte({7'h4E, 1'b0}, ack); send_byte(8'h20, ack);
    bus_start(); send_byte({7'h4E, 1'b1}, ack);
    for (int k = 0; k < 3; k++) begin
      get_byte(k != 2, b);
      check(b == exp_mem[8'h20 + k], "R5/R6 burst read", 32'(b), 32'(exp_mem[8'h20 + k]));
    end
    oe_seen = 1'b0;
    get_byte(1'b0, b);  // after NACK the slave must stay silent
    check(oe_seen == 1'b0 && b == 8'hFF, "R6 silent after nack", {oe_seen, b}, 32'hFF);
    bus_stop();
    bus_start(); send_byte({7'h4E, 1'b1}, ack); get_byte(1'b0, b); bus_stop();
    check(b == exp_mem[8'h23], "R11 pointer carried over", 32'(b), 32'(exp_mem[8'h23]));

    // pointer wrap
    bus_start(); send_byte({7'h4E, 1'b0}, ack); send_byte(8'hFF, ack);
    send_byte(8'hAB, ack); send_byte(8'hCD, ack); bus_stop();
    check(mem[8'hFF] == 8'hAB && mem[8'h00] == 8'hCD, "R4 wrap", {mem[8'hFF], mem[8'h00]}, 32'hABCD);
    check(last_addr == 8'h00, "R4 wrap strobe address", 32'(last_addr), 0);

    // select pins follow
    sel = 2'b01;
    bus_start(); send_byte({7'h4D, 1'b0}, ack); bus_stop();
    check(ack, "R1 new select address", 32'(ack), 1);
    bus_start(); send_byte({7'h4E, 1'b0}, ack); bus_stop();
    check(!ack, "R2 old address refused", 32'(ack), 0);

    // stop in the middle of a byte
    bus_start();
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    bus_stop();
    check(sda_oe == 1'b0, "R8 released after stop", 32'(sda_oe), 0);
    bus_start(); send_byte({7'h4D, 1'b0}, ack); bus_stop();
    check(ack, "R8 recovers after broken byte", 32'(ack), 1);

    check(scl_hi_changes == 0, "R9 drive changes only with SCL low", 32'(scl_hi_changes), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule